// File: doc/BRIEF.md
# Event-Based Branch Dispatcher

This block turns a pending performance-monitor interrupt into a branch to a handler that runs in user state. It holds three registers: a small control/status register with two enables and an "event occurred" flag, a handler address register, and a return address register. When the processor is in user state and an interrupt is pending, the block acknowledges the request so the interrupt controller can drop it. If both enables are set, the block then redirects the program counter to the handler and records the interrupted address.

If either enable is clear, the request is still acknowledged but is dropped without trace. Outside user state the request is left pending and is not acknowledged. A return request reloads the program counter from the return register and re-arms the global enable. Software loads the three registers through a simple write port.

Top module: `ebx_dispatch`

## Requirements
- R1: After reset all three registers read zero and neither the redirect strobe nor the acknowledge is asserted.
- R2: `ack_o` is high in a cycle only when `irq_pend_i` and `user_mode_i` are both high and `ret_req_i` is low. Outside user state a pending request gets no acknowledge.
- R3: An acknowledged request causes a branch only when status bit 0 (global enable) and status bit 1 (monitor-event enable) are both set.
- R4: On a branch, status bit 0 is cleared, status bit 2 (event occurred) is set and bit 1 keeps its value.
- R5: On a branch, the return register receives `pc_i` with its two low bits forced to zero, and the redirect target is the handler register value.
- R6: An acknowledged request with either enable clear produces no redirect and leaves all three registers unchanged.
- R7: The redirect strobe is high for exactly one cycle, namely the cycle after the accepting cycle.
- R8: A return request redirects to the return register value and sets status bit 0. It takes precedence over a pending interrupt, which is not acknowledged in that cycle.
- R9: Writes select a register by `wr_sel_i`: 0 selects status (bits 2:0), 1 selects handler, 2 selects return, and 3 selects nothing. Handler and return values have their low two bits forced to zero.
- R10: A register write issued in a cycle with an acknowledge or a return request is discarded.
- R11: A second request that arrives after a branch, with the global enable still clear, is acknowledged and dropped without a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend_i | input | 1 | Pending performance-monitor interrupt |
| pc_i | input | AW | Address of the interrupted instruction |
| user_mode_i | input | 1 | Processor is in user (problem) state |
| ret_req_i | input | 1 | Return-from-event-branch request |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 status, 1 handler, 2 return, 3 none |
| wr_data_i | input | AW | Write data |
| ack_o | output | 1 | Pending request consumed this cycle |
| redir_o | output | 1 | One-cycle program-counter redirect strobe |
| redir_tgt_o | output | AW | Redirect target address |
| status_o | output | 3 | Status: bit0 global enable, bit1 event enable, bit2 occurred |
| handler_o | output | AW | Handler address register |
| retaddr_o | output | AW | Return address register |

## Verification
The bench sweeps every combination of privilege state, the two enables and a concurrent return request. It computes the expected acknowledge, redirect, target and register values for each case. A dispatcher that accepted requests in supervisor state, or that ignored one of the enables, would produce an acknowledge or a redirect where none is due. One that branched on a disabled event would clobber the return register. Further directed cases cover back-to-back requests after a branch, where a design that failed to clear the global enable would redirect twice. They also cover writes that collide with an event, which a wrong design would let corrupt the handler, and misaligned addresses, whose low bits must never reach a register.

// File: rtl/ebx_pkg.sv
// Shared definitions for the event-based branch dispatcher.
// Assumes the status register is three bits wide with fixed field positions.
package ebx_pkg;
    localparam int ST_W  = 3;
    localparam int ST_GE = 0;  // global enable
    localparam int ST_ME = 1;  // monitor-event enable
    localparam int ST_MO = 2;  // monitor event occurred

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_HNDL = 2'd1,
        SEL_RET  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;
endpackage

// File: rtl/ebx_gate.sv
// Acceptance logic: decides whether a pending request is consumed this cycle
// and whether it becomes a branch, or whether a return request is taken.
// Assumes the return request has precedence over a pending interrupt.
module ebx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pend_i,
    input  logic user_mode_i,
    input  logic ret_req_i,
    input  logic glb_en_i,
    input  logic ev_en_i,
    output logic ack_o,
    output logic take_branch_o,
    output logic take_return_o
);
    // Combinational acceptance and branch decision.
    always_comb begin
        take_return_o = ret_req_i;
        ack_o         = irq_pend_i && user_mode_i && !ret_req_i;
        take_branch_o = ack_o && glb_en_i && ev_en_i;
    end

    // R2: an acknowledge needs a pending request in user state
    a_r2_ack_user: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (user_mode_i && irq_pend_i));
    // R8: a return request suppresses the acknowledge
    a_r8_ret_first: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req_i |-> !ack_o);
endmodule

// File: rtl/ebx_regs.sv
// Status, handler and return registers with hardware update on branch and
// return. Assumes software writes lose to a hardware event in the same cycle.
module ebx_regs #(
    parameter int AW    = 32,
    parameter int ALIGN = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ack_i,
    input  logic                   take_branch_i,
    input  logic                   take_return_i,
    input  logic [AW-1:0]          pc_i,
    input  logic                   wr_en_i,
    input  ebx_pkg::wsel_e         wr_sel_i,
    input  logic [AW-1:0]          wr_data_i,
    output logic [ebx_pkg::ST_W-1:0] status_o,
    output logic [AW-1:0]          handler_o,
    output logic [AW-1:0]          retaddr_o
);
    import ebx_pkg::*;
    localparam logic [AW-1:0] AMASK = {{(AW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

    logic [ST_W-1:0] status_q;
    logic [AW-1:0]   handler_q;
    logic [AW-1:0]   ret_q;
    logic            hw_evt;
    logic            sw_wr;

    // Any hardware event blocks the software write port.
    always_comb begin
        hw_evt = ack_i || take_return_i;
        sw_wr  = wr_en_i && !hw_evt;
    end

    // Status register: hardware update first, otherwise software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (take_return_i) begin
            status_q[ST_GE] <= 1'b1;
        end else if (take_branch_i) begin
            status_q[ST_GE] <= 1'b0;
            status_q[ST_MO] <= 1'b1;
        end else if (sw_wr && wr_sel_i == SEL_STAT) begin
            status_q <= wr_data_i[ST_W-1:0];
        end
    end

    // Handler register: software write only, word aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_q <= '0;
        end else if (sw_wr && wr_sel_i == SEL_HNDL) begin
            handler_q <= wr_data_i & AMASK;
        end
    end

    // Return register: captures the interrupted address on a branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else if (take_branch_i) begin
            ret_q <= pc_i & AMASK;
        end else if (sw_wr && wr_sel_i == SEL_RET) begin
            ret_q <= wr_data_i & AMASK;
        end
    end

    assign status_o  = status_q;
    assign handler_o = handler_q;
    assign retaddr_o = ret_q;

    // R4: a branch clears global enable and sets the occurred flag
    a_r4_branch_status: assert property (@(posedge clk) disable iff (!rst_n)
        take_branch_i |=> (!status_q[ST_GE] && status_q[ST_MO]));
    // R5: the return register holds the aligned interrupted address
    a_r5_ret_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take_branch_i |=> (ret_q == ($past(pc_i) & AMASK)));
    // R6: a dropped request changes no register
    a_r6_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !take_branch_i) |=>
            ($stable(status_q) && $stable(handler_q) && $stable(ret_q)));
    // R9: address registers never hold low bits
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_q[ALIGN-1:0] == '0) && (ret_q[ALIGN-1:0] == '0));
    // R10: a colliding write leaves the handler register alone
    a_r10_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt && wr_en_i && wr_sel_i == SEL_HNDL) |=> $stable(handler_q));
endmodule

// File: rtl/ebx_redirect.sv
// Registers the program-counter redirect strobe and its target.
// Assumes the return register value sampled is the one before this edge.
module ebx_redirect #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_branch_i,
    input  logic          take_return_i,
    input  logic [AW-1:0] handler_i,
    input  logic [AW-1:0] retaddr_i,
    output logic          redir_o,
    output logic [AW-1:0] redir_tgt_o
);
    // Strobe and target register, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_o     <= 1'b0;
            redir_tgt_o <= '0;
        end else begin
            redir_o <= take_branch_i || take_return_i;
            if (take_return_i) begin
                redir_tgt_o <= retaddr_i;
            end else if (take_branch_i) begin
                redir_tgt_o <= handler_i;
            end
        end
    end

    // R7: every strobe follows an accepted branch or return
    a_r7_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> $past(take_branch_i || take_return_i));
    // R5: a branch redirects to the handler address
    a_r5_target: assert property (@(posedge clk) disable iff (!rst_n)
        (take_branch_i && !take_return_i) |=> (redir_tgt_o == $past(handler_i)));
endmodule

// File: rtl/ebx_dispatch.sv
// Top of the event-based branch dispatcher: acceptance gate, register file
// and redirect stage. Assumes one request is presented per cycle at most.
module ebx_dispatch #(
    parameter int AW    = 32,
    parameter int ALIGN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_pend_i,
    input  logic [AW-1:0] pc_i,
    input  logic          user_mode_i,
    input  logic          ret_req_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [AW-1:0] wr_data_i,
    output logic          ack_o,
    output logic          redir_o,
    output logic [AW-1:0] redir_tgt_o,
    output logic [2:0]    status_o,
    output logic [AW-1:0] handler_o,
    output logic [AW-1:0] retaddr_o
);
    import ebx_pkg::*;

    logic take_branch;
    logic take_return;
    logic ack;
    wsel_e wsel;

    assign wsel  = wsel_e'(wr_sel_i);
    assign ack_o = ack;

    ebx_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_pend_i    (irq_pend_i),
        .user_mode_i   (user_mode_i),
        .ret_req_i     (ret_req_i),
        .glb_en_i      (status_o[ST_GE]),
        .ev_en_i       (status_o[ST_ME]),
        .ack_o         (ack),
        .take_branch_o (take_branch),
        .take_return_o (take_return)
    );

    ebx_regs #(.AW(AW), .ALIGN(ALIGN)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .ack_i         (ack),
        .take_branch_i (take_branch),
        .take_return_i (take_return),
        .pc_i          (pc_i),
        .wr_en_i       (wr_en_i),
        .wr_sel_i      (wsel),
        .wr_data_i     (wr_data_i),
        .status_o      (status_o),
        .handler_o     (handler_o),
        .retaddr_o     (retaddr_o)
    );

    ebx_redirect #(.AW(AW)) u_redir (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_branch_i (take_branch),
        .take_return_i (take_return),
        .handler_i     (handler_o),
        .retaddr_i     (retaddr_o),
        .redir_o       (redir_o),
        .redir_tgt_o   (redir_tgt_o)
    );

    // R3: no branch without both enables
    a_r3_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(status_o[ST_GE] && status_o[ST_ME])) |=> !redir_o);
    // R11: after a branch the global enable blocks a further one
    a_r11_no_rebranch: assert property (@(posedge clk) disable iff (!rst_n)
        (take_branch && !take_return) |=> (!take_branch));
endmodule

// File: tb/sim_ebx_dispatch.sv
module sim_ebx_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_pend_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        user_mode_i = 1'b0;
    logic        ret_req_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd3;
    logic [31:0] wr_data_i = '0;
    logic        ack_o, redir_o;
    logic [31:0] redir_tgt_o, handler_o, retaddr_o;
    logic [2:0]  status_o;

    int n_run = 0;
    int n_fail = 0;

    ebx_dispatch u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_sel_i = 2'd3;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 status", {29'd0, status_o}, 32'd0);
        chk("R1 handler", handler_o, 32'd0);
        chk("R1 retaddr", retaddr_o, 32'd0);
        chk("R1 redir", {31'd0, redir_o}, 32'd0);
        chk("R1 ack", {31'd0, ack_o}, 32'd0);

        // Sweep: c[0] user, c[1] global enable, c[2] event enable, c[3] return
        for (int c = 0; c < 16; c++) begin
            logic usr, ge, me, rt, acc, br;
            logic [31:0] h, r, p, exp_ret, exp_tgt;
            logic [2:0] exp_st;
            logic exp_redir;
            usr = c[0]; ge = c[1]; me = c[2]; rt = c[3];
            h = 32'h0000_1000 + c * 16 + 3;
            r = 32'h0000_8000 + c * 8 + 1;
            p = 32'h4000_0000 + c * 4 + 2;
            wr(2'd0, {29'd0, 1'b0, me, ge});
            wr(2'd1, h);
            wr(2'd2, r);
            chk("R9 handler aligned", handler_o, h & ~32'd3);
            chk("R9 retaddr aligned", retaddr_o, r & ~32'd3);
            chk("R9 status write", {29'd0, status_o}, {29'd0, 1'b0, me, ge});
            acc = usr && !rt;
            br  = acc && ge && me;
            exp_redir = rt || br;
            exp_tgt = rt ? (r & ~32'd3) : (h & ~32'd3);
            exp_ret = br ? (p & ~32'd3) : (r & ~32'd3);
            exp_st = rt ? {1'b0, me, 1'b1} : (br ? {1'b1, me, 1'b0} : {1'b0, me, ge});
            @(negedge clk);
            irq_pend_i = 1'b1; user_mode_i = usr; ret_req_i = rt; pc_i = p;
            #1;
            chk("R2 ack", {31'd0, ack_o}, {31'd0, acc});
            @(negedge clk);
            irq_pend_i = 1'b0; ret_req_i = 1'b0;
            #1;
            chk("R7 redir strobe", {31'd0, redir_o}, {31'd0, exp_redir});
            if (exp_redir) chk(rt ? "R8 return target" : "R5 handler target", redir_tgt_o, exp_tgt);
            chk(br ? "R4 status" : (rt ? "R8 status" : "R6 status"), {29'd0, status_o}, {29'd0, exp_st});
            chk(br ? "R5 retaddr" : "R6 retaddr", retaddr_o, exp_ret);
            chk("R6 handler", handler_o, h & ~32'd3);
            @(negedge clk);
            #1;
            chk("R7 single pulse", {31'd0, redir_o}, 32'd0);
        end

        // R10 and R11: branch with a colliding write, then a second request
        wr(2'd0, 32'd3);
        wr(2'd1, 32'h0000_2000);
        @(negedge clk);
        irq_pend_i = 1'b1; user_mode_i = 1'b1; pc_i = 32'h0000_5555;
        wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = 32'h0000_9990;
        @(negedge clk);
        wr_en_i = 1'b0; wr_sel_i = 2'd3;
        #1;
        chk("R10 write discarded", handler_o, 32'h0000_2000);
        chk("R5 redirect", {31'd0, redir_o}, 32'd1);
        chk("R5 retaddr aligned", retaddr_o, 32'h0000_5554);
        chk("R11 second ack", {31'd0, ack_o}, 32'd1);
        @(negedge clk);
        irq_pend_i = 1'b0;
        #1;
        chk("R11 no redirect", {31'd0, redir_o}, 32'd0);
        chk("R11 status kept", {29'd0, status_o}, 32'd6);
        chk("R11 retaddr kept", retaddr_o, 32'h0000_5554);

        // R9: selector 3 writes nothing
        wr(2'd3, 32'hFFFF_FFFF);
        chk("R9 none handler", handler_o, 32'h0000_2000);
        chk("R9 none status", {29'd0, status_o}, 32'd6);

        // R2: kernel state keeps request pending
        @(negedge clk);
        irq_pend_i = 1'b1; user_mode_i = 1'b0;
        #1;
        chk("R2 kernel no ack", {31'd0, ack_o}, 32'd0);
        @(negedge clk);
        irq_pend_i = 1'b0;
        #1;
        chk("R2 kernel no redirect", {31'd0, redir_o}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule